// File: doc/BRIEF.md
# Fractional UART baud generator

This block produces the 16x-oversampling tick enable for a UART. The tick rate is set by a divisor with an integer part and a fractional part. For a wanted baud rate the divisor is the input clock divided by sixteen times that rate. The fractional part lets the average tick period be a non-integer number of clocks, so the baud rate can be set more finely than an integer divisor allows.

Software reaches the block through a small word-addressed register port. There is a low byte and a high byte of the 16-bit integer divisor, and a fraction register whose width is fixed at build time to between 4 and 6 bits. Fraction bits above the built width are not stored and always read as zero. Software can therefore write all ones to the fraction register, read it back, and take the position of the highest set bit as the width.

Inside the block, an accumulator as wide as the fraction adds the fraction once per tick period. Each period whose addition carries out gets one extra clock. A fraction of zero gives plain integer division. A new divisor or fraction value is applied only when a period ends.

Top module: `frac_baud_gen`

## Requirements
- R1: After synchronous reset, `tick` is low and reads of the low divisor byte, the high divisor byte and the fraction register all return 0.
- R2: The divisor low byte is at offset 0x00 and the high byte at offset 0x04. Each stores `wdata[7:0]`, and a read returns the stored byte with all other bits zero.
- R3: The fraction register is at offset 0xC0. It stores only `wdata[FRAC_W-1:0]`. Higher read bits are always zero, so writing all ones reads back as 2^FRAC_W-1.
- R4: With a fraction of 0 and integer divisor I, the tick repeats exactly every I clocks.
- R5: With fraction F and integer divisor I, every tick period is I or I+1 clocks long, and any 2^FRAC_W consecutive periods add up to exactly I*2^FRAC_W+F clocks.
- R6: When the period is at least 2 clocks, `tick` is high for exactly one clock.
- R7: An integer divisor of 0 gives no ticks. If the divisor is set to 0 while running, the period in progress ends with one last tick. After that no tick appears, and the accumulator and counter are cleared.
- R8: A divisor written during a period does not change that period. It sets the length of the following period.
- R9: When the generator is idle and a nonzero divisor I is written, the first tick is seen I+1 clocks after the clock edge that takes the write.
- R10: Reads are registered. `rdata` carries the value addressed by a read one clock after `rd_en`, holds it until the next read, and returns 0 for unmapped offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register (word aligned) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| tick | output | 1 | One-clock 16x-baud enable pulse |

## Verification
A wrong accumulator value shows at the ports as a misplaced long period. Within one 2^FRAC_W-tick window the sum of the periods is then wrong, so the bench measures every period and checks both the sum and the spread. A corrupted period limit or counter changes the very next tick spacing. A run flag that is stuck or cleared too early shows up as missing or extra ticks right after a divisor change: the first tick comes late, or ticks continue after a zero divisor.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int DIV_W = 16;
  localparam logic [7:0] OFF_DIV_LO = 8'h00;
  localparam logic [7:0] OFF_DIV_HI = 8'h04;
  localparam logic [7:0] OFF_FRAC   = 8'hC0;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs #(
  parameter int FRAC_W = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_val,
  output logic [FRAC_W-1:0] frac_val
);
  import fbg_pkg::*;
  localparam int BYTE_W = DIV_W / 2;

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [FRAC_W-1:0] frac_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic sel_lo, sel_hi, sel_frac;

  assign sel_lo   = (addr == ADDR_W'(OFF_DIV_LO));
  assign sel_hi   = (addr == ADDR_W'(OFF_DIV_HI));
  assign sel_frac = (addr == ADDR_W'(OFF_FRAC));

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      frac_q <= '0;
    end else if (wr_en) begin
      if (sel_lo)   lo_q   <= wdata[BYTE_W-1:0];
      if (sel_hi)   hi_q   <= wdata[BYTE_W-1:0];
      if (sel_frac) frac_q <= wdata[FRAC_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_lo)   rd_mux[BYTE_W-1:0] = lo_q;
    if (sel_hi)   rd_mux[BYTE_W-1:0] = hi_q;
    if (sel_frac) rd_mux[FRAC_W-1:0] = frac_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata    = rdata_q;
  assign div_val  = {hi_q, lo_q};
  assign frac_val = frac_q;
endmodule

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              to_zero,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, frac_in};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= to_zero ? '0 : sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/fbg_tick_cnt.sv
module fbg_tick_cnt #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] lim_in,
  output logic             wrap,
  output logic             tick,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] lim
);
  logic [DIV_W-1:0] cnt_q, lim_q;
  logic             tick_q;

  assign wrap = run && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (load) begin
        cnt_q <= '0;
        lim_q <= lim_in;
      end else if (run) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick = tick_q;
  assign cnt  = cnt_q;
  assign lim  = lim_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int FRAC_W = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick
);
  localparam int DIV_W = fbg_pkg::DIV_W;

  logic [DIV_W-1:0]  div_val, lim_next, cnt_w, lim_w;
  logic [FRAC_W-1:0] frac_val;
  logic run_q, div_nz, start, wrap, advance, carry;

  fbg_regs #(.FRAC_W(FRAC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .div_val(div_val), .frac_val(frac_val)
  );

  assign div_nz  = |div_val;
  assign start   = !run_q && div_nz;
  assign advance = start || wrap;

  fbg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .step(advance), .to_zero(!div_nz),
    .frac_in(frac_val), .carry(carry)
  );

  assign lim_next = div_nz ? (div_val - 1'b1 + DIV_W'(carry)) : '0;

  fbg_tick_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .load(advance), .lim_in(lim_next),
    .wrap(wrap), .tick(tick), .cnt(cnt_w), .lim(lim_w)
  );

  always_ff @(posedge clk) begin
    if (rst)          run_q <= 1'b0;
    else if (advance) run_q <= div_nz;
  end
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int FRAC_W = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              run,
  input logic              wrap,
  input logic [DIV_W-1:0]  cnt,
  input logic [DIV_W-1:0]  lim,
  input logic [DIV_W-1:0]  div_val
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !tick);

  a_r3_frac_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(fbg_pkg::OFF_FRAC)) |=> (rdata[DATA_W-1:FRAC_W] == '0));

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= lim));

  a_r7_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick);

  a_r7_zero_div_stops: assert property (@(posedge clk) disable iff (rst)
    (wrap && div_val == '0) |=> !run);

  a_r8_limit_held: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(lim));
endmodule

bind frac_baud_gen fbg_checker #(
  .FRAC_W(FRAC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .run(run_q), .wrap(wrap), .cnt(cnt_w), .lim(lim_w), .div_val(div_val)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  localparam int FRAC_W = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int NPER   = 1 << FRAC_W;
  localparam int NVEC   = 9;
  // columns: integer divisor, fraction, expected clocks over NPER periods
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{1, 0, 16}, '{1, 8, 24}, '{1, 15, 31}, '{2, 1, 33}, '{3, 15, 63},
    '{5, 5, 85}, '{7, 0, 112}, '{10, 3, 163}, '{2, 7, 39}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic tick;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  frac_baud_gen #(.FRAC_W(FRAC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frac_baud_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = 8'h10;
    v = int'(rdata);
  endtask

  task automatic wait_tick(output int c);
    do @(negedge clk); while (!tick);
    c = cyc;
  endtask

  initial begin
    int v, c0, c1, c2, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(tick == 1'b0, "R1 tick", int'(tick), 0);
    rd(8'h00, v); chk(v == 0, "R1 lo", v, 0);
    rd(8'h04, v); chk(v == 0, "R1 hi", v, 0);
    rd(8'hC0, v); chk(v == 0, "R1 frac", v, 0);
    // R7 zero divisor from reset gives no ticks
    n = 0;
    repeat (50) begin @(negedge clk); if (tick) n++; end
    chk(n == 0, "R7 idle ticks", n, 0);
    // R3 width probe, R2 low byte masking, R10 unmapped and hold
    wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0, v); chk(v == 15, "R3 probe", v, 15);
    wr(8'hC0, 32'h0000_0000); rd(8'hC0, v); chk(v == 0, "R3 clear", v, 0);
    rd(8'h08, v); chk(v == 0, "R10 unmapped", v, 0);
    wr(8'hC0, 32'h0000_0025); rd(8'hC0, v); chk(v == 5, "R3 masked", v, 5);
    @(negedge clk); chk(int'(rdata) == 5, "R10 hold", int'(rdata), 5);
    wr(8'hC0, 32'h0);

    // table walk: R4 and R5
    for (int i = 0; i < NVEC; i++) begin
      int di, fr, tot, mn, mx, p;
      di = VEC[i][0]; fr = VEC[i][1];
      wr(8'hC0, 32'(fr));
      wr(8'h00, 32'(di));
      wait_tick(c0);
      tot = 0; mn = 1 << 30; mx = 0;
      for (int k = 0; k < NPER; k++) begin
        wait_tick(c1);
        p = c1 - c0; c0 = c1; tot += p;
        if (p < mn) mn = p;
        if (p > mx) mx = p;
      end
      chk(tot == VEC[i][2], "R5 window total", tot, VEC[i][2]);
      chk(mn >= di && mx <= di + 1, "R5 period spread", mx - mn, 1);
      if (fr == 0) chk(mn == di && mx == di, "R4 integer period", mx, di);
      wr(8'h00, 32'h0);
      repeat (di + 6) @(negedge clk);
    end
    wr(8'hC0, 32'h0);

    // R9 first tick latency from idle
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h00; wdata = 32'd5;
    @(negedge clk);
    wr_en = 1'b0; c0 = cyc;
    wait_tick(c1);
    chk(c1 - c0 == 6, "R9 first tick", c1 - c0, 6);

    // R6 single clock pulse at period 2
    wr(8'h00, 32'd2);
    wait_tick(c0); wait_tick(c0);
    @(negedge clk);
    chk(tick == 1'b0, "R6 pulse width", int'(tick), 0);

    // R8 change applied at boundary
    wr(8'h00, 32'd20);
    wait_tick(c0); wait_tick(c0);
    repeat (5) @(negedge clk);
    wr(8'h00, 32'd4);
    wait_tick(c1); wait_tick(c2);
    chk(c1 - c0 == 20, "R8 current period kept", c1 - c0, 20);
    chk(c2 - c1 == 4, "R8 new period", c2 - c1, 4);

    // R7 stopping while running
    wr(8'h00, 32'd6);
    wait_tick(c0); wait_tick(c0);
    repeat (2) @(negedge clk);
    wr(8'h00, 32'd0);
    wait_tick(c1);
    chk(c1 - c0 == 6, "R7 last period", c1 - c0, 6);
    n = 0;
    repeat (100) begin @(negedge clk); if (tick) n++; end
    chk(n == 0, "R7 stopped", n, 0);

    // R2 high byte readback with upper bits discarded
    wr(8'h04, 32'h0000_01AB); rd(8'h04, v); chk(v == 32'hAB, "R2 hi", v, 32'hAB);
    wr(8'h00, 32'h00FF_FF3C); rd(8'h00, v); chk(v == 32'h3C, "R2 lo", v, 32'h3C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule